// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block tracks, for every hardware thread of an instruction fetch stage, a small status state machine, four stall flags and the redirect program counters. Each cycle it merges stall strobes from four downstream stages, redirect requests from the commit and decode stages, a "reorder buffer still flushing" level, a global context-switch level and instruction-cache handshake events. From these it picks one outcome per thread under a fixed priority order.

The fetch datapath reads the per-thread status to decide which thread may issue a cache request. It reads the PC, NPC and next-NPC registers to restart after a redirect. It uses `miss_drop` to discard a cache request that a redirect has made stale. `stage_active` tells the clock/activity logic whether any enabled thread can make progress.

Top module: `fetch_thread_status`

## Requirements
- R1: After reset every thread's status is Running (code 0), all stall flags are clear, PC = RST_PC, NPC = RST_PC+ISZ, next-NPC = RST_PC+2*ISZ, and `miss_drop` and `status_chg` are low.
- R2: Each thread has four stall flags (decode, rename, execute, commit). A flag is set by its block strobe and cleared by its unblock strobe. Driving an unblock while the flag is clear, or in the same cycle as its block, is illegal. While any flag is set, a thread that is not waiting on the cache enters Blocked (code 2).
- R3: A commit redirect outranks every other event. One cycle later the status is Squashing (code 1), PC = the commit redirect PC, NPC = the commit redirect NPC, and next-NPC = NPC + ISZ.
- R4: Without a commit redirect, the reorder-buffer-busy level puts or keeps the thread in Squashing and leaves its PCs unchanged.
- R5: A decode redirect loads PC, NPC and next-NPC as in R3, and moves the thread to Squashing, but only when the thread is not already Squashing. Otherwise it is ignored.
- R6: A context switch blocks every thread the same way as a stall flag. Threads in WaitResponse (code 3) or WaitRetry (code 4) are exempt from blocking.
- R7: A thread in Blocked or Squashing with no squash and no stall in a cycle returns to Running.
- R8: Cache events apply only when no higher-priority rule fires. From Running or AccessComplete (code 5), a request enters WaitResponse, or WaitRetry if it is nacked in the same cycle. A retry grant moves WaitRetry to WaitResponse. A response moves WaitResponse to AccessComplete, or to Blocked if the thread is stalled. A response in any other state is ignored.
- R9: When a thread in WaitResponse or WaitRetry is squashed (by commit, reorder-buffer busy or an accepted decode redirect), `miss_drop` pulses for one cycle, aligned with the new status.
- R10: `stage_active` is high exactly when some thread with its `thr_act` bit set is Running, Squashing or AccessComplete.
- R11: `status_chg` is high for one cycle on a thread exactly when the previous edge applied one of the rules R3–R8 to that thread. This includes a rewrite to the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_act | input | NTHR | Thread enabled mask used for stage_active |
| dec_blk | input | NTHR | Decode block strobe per thread |
| dec_unblk | input | NTHR | Decode unblock strobe per thread |
| ren_blk | input | NTHR | Rename block strobe |
| ren_unblk | input | NTHR | Rename unblock strobe |
| exe_blk | input | NTHR | Execute block strobe |
| exe_unblk | input | NTHR | Execute unblock strobe |
| cmt_blk | input | NTHR | Commit block strobe |
| cmt_unblk | input | NTHR | Commit unblock strobe |
| ctx_sw | input | 1 | Context switch in progress |
| cmt_sq | input | NTHR | Commit redirect per thread |
| cmt_pc | input | NTHR*AW | Commit redirect PC per thread |
| cmt_npc | input | NTHR*AW | Commit redirect NPC per thread |
| rob_busy | input | NTHR | Reorder buffer still flushing |
| dec_sq | input | NTHR | Decode redirect per thread |
| dec_pc | input | NTHR*AW | Decode redirect PC |
| dec_npc | input | NTHR*AW | Decode redirect NPC |
| ic_req | input | NTHR | Cache request issued |
| ic_nack | input | NTHR | Request refused, must retry |
| ic_resp | input | NTHR | Cache response for the thread |
| ic_retry_ok | input | NTHR | Retry accepted by cache |
| status_o | output | NTHR*3 | Status code per thread |
| pc_o | output | NTHR*AW | PC per thread |
| npc_o | output | NTHR*AW | NPC per thread |
| nnpc_o | output | NTHR*AW | Next-NPC per thread |
| miss_drop | output | NTHR | Outstanding cache request discarded |
| status_chg | output | NTHR | Status register written last edge |
| stage_active | output | 1 | Some enabled thread can progress |

## Verification
The hardest case to reach is a cache response that lands while the thread is stalled, because the thread must first be parked in WaitResponse where the stall cannot block it. The bench issues a request, raises the context switch while the request is outstanding, and then returns the response with the switch still high; the expected result is Blocked, not AccessComplete. A long random phase follows. It keeps the block/unblock protocol legal from the model's own flag state and mixes redirects, flushes and cache events, so that redirects hitting WaitRetry and WaitResponse also occur.

// File: rtl/fetch_thread_status.sv
module fetch_thread_status #(
  parameter int NTHR = 2,
  parameter int AW = 32,
  parameter int ISZ = 4,
  parameter logic [AW-1:0] RST_PC = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTHR-1:0]     thr_act,
  input  logic [NTHR-1:0]     dec_blk,
  input  logic [NTHR-1:0]     dec_unblk,
  input  logic [NTHR-1:0]     ren_blk,
  input  logic [NTHR-1:0]     ren_unblk,
  input  logic [NTHR-1:0]     exe_blk,
  input  logic [NTHR-1:0]     exe_unblk,
  input  logic [NTHR-1:0]     cmt_blk,
  input  logic [NTHR-1:0]     cmt_unblk,
  input  logic                ctx_sw,
  input  logic [NTHR-1:0]     cmt_sq,
  input  logic [NTHR*AW-1:0]  cmt_pc,
  input  logic [NTHR*AW-1:0]  cmt_npc,
  input  logic [NTHR-1:0]     rob_busy,
  input  logic [NTHR-1:0]     dec_sq,
  input  logic [NTHR*AW-1:0]  dec_pc,
  input  logic [NTHR*AW-1:0]  dec_npc,
  input  logic [NTHR-1:0]     ic_req,
  input  logic [NTHR-1:0]     ic_nack,
  input  logic [NTHR-1:0]     ic_resp,
  input  logic [NTHR-1:0]     ic_retry_ok,
  output logic [NTHR*3-1:0]   status_o,
  output logic [NTHR*AW-1:0]  pc_o,
  output logic [NTHR*AW-1:0]  npc_o,
  output logic [NTHR*AW-1:0]  nnpc_o,
  output logic [NTHR-1:0]     miss_drop,
  output logic [NTHR-1:0]     status_chg,
  output logic                stage_active
);
  localparam logic [2:0] S_RUN  = 3'd0;
  localparam logic [2:0] S_SQ   = 3'd1;
  localparam logic [2:0] S_BLK  = 3'd2;
  localparam logic [2:0] S_WRSP = 3'd3;
  localparam logic [2:0] S_WRTY = 3'd4;
  localparam logic [2:0] S_DONE = 3'd5;
  localparam logic [AW-1:0] STEP = AW'(ISZ);

  logic [NTHR-1:0] fl_dec, fl_ren, fl_exe, fl_cmt;
  logic [NTHR-1:0] nf_dec, nf_ren, nf_exe, nf_cmt;
  logic [NTHR-1:0] stall_d, wr_d, redir_d, drop_d;
  logic [2:0]      st_q [NTHR];
  logic [2:0]      st_d [NTHR];
  logic [AW-1:0]   rpc_d [NTHR];
  logic [AW-1:0]   rnpc_d [NTHR];

  assign nf_dec  = dec_blk | (fl_dec & ~dec_unblk);
  assign nf_ren  = ren_blk | (fl_ren & ~ren_unblk);
  assign nf_exe  = exe_blk | (fl_exe & ~exe_unblk);
  assign nf_cmt  = cmt_blk | (fl_cmt & ~cmt_unblk);
  assign stall_d = nf_dec | nf_ren | nf_exe | nf_cmt | {NTHR{ctx_sw}};

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      logic waiting;
      waiting    = (st_q[t] == S_WRSP) || (st_q[t] == S_WRTY);
      st_d[t]    = st_q[t];
      wr_d[t]    = 1'b1;
      redir_d[t] = 1'b0;
      drop_d[t]  = 1'b0;
      rpc_d[t]   = cmt_pc[t*AW +: AW];
      rnpc_d[t]  = cmt_npc[t*AW +: AW];
      if (cmt_sq[t]) begin
        st_d[t] = S_SQ; redir_d[t] = 1'b1; drop_d[t] = waiting;
      end else if (rob_busy[t]) begin
        st_d[t] = S_SQ; drop_d[t] = waiting;
      end else if (dec_sq[t] && st_q[t] != S_SQ) begin
        st_d[t] = S_SQ; redir_d[t] = 1'b1; drop_d[t] = waiting;
        rpc_d[t]  = dec_pc[t*AW +: AW];
        rnpc_d[t] = dec_npc[t*AW +: AW];
      end else if (stall_d[t] && !waiting) begin
        st_d[t] = S_BLK;
      end else if (st_q[t] == S_BLK || st_q[t] == S_SQ) begin
        st_d[t] = S_RUN;
      end else if ((st_q[t] == S_RUN || st_q[t] == S_DONE) && ic_req[t]) begin
        st_d[t] = ic_nack[t] ? S_WRTY : S_WRSP;
      end else if (st_q[t] == S_WRSP && ic_resp[t]) begin
        st_d[t] = stall_d[t] ? S_BLK : S_DONE;
      end else if (st_q[t] == S_WRTY && ic_retry_ok[t]) begin
        st_d[t] = S_WRSP;
      end else begin
        wr_d[t] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_dec <= '0; fl_ren <= '0; fl_exe <= '0; fl_cmt <= '0;
      miss_drop  <= '0;
      status_chg <= '0;
      pc_o   <= {NTHR{RST_PC}};
      npc_o  <= {NTHR{RST_PC + STEP}};
      nnpc_o <= {NTHR{RST_PC + STEP + STEP}};
      for (int t = 0; t < NTHR; t++) st_q[t] <= S_RUN;
    end else begin
      fl_dec <= nf_dec; fl_ren <= nf_ren; fl_exe <= nf_exe; fl_cmt <= nf_cmt;
      miss_drop  <= drop_d;
      status_chg <= wr_d;
      for (int t = 0; t < NTHR; t++) begin
        st_q[t] <= st_d[t];
        if (redir_d[t]) begin
          pc_o[t*AW +: AW]   <= rpc_d[t];
          npc_o[t*AW +: AW]  <= rnpc_d[t];
          nnpc_o[t*AW +: AW] <= rnpc_d[t] + STEP;
        end
      end
    end
  end

  always_comb begin
    stage_active = 1'b0;
    for (int t = 0; t < NTHR; t++) begin
      status_o[t*3 +: 3] = st_q[t];
      if (thr_act[t] && (st_q[t] == S_RUN || st_q[t] == S_SQ || st_q[t] == S_DONE))
        stage_active = 1'b1;
    end
  end
endmodule

// File: rtl/fetch_thread_status_chk.sv
module fetch_thread_status_chk #(
  parameter int NT = 2,
  parameter int AW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NT-1:0]    cmt_sq,
  input logic [NT-1:0]    rob_busy,
  input logic [NT-1:0]    dec_sq,
  input logic [NT-1:0]    ic_resp,
  input logic [NT-1:0]    ic_retry_ok,
  input logic [NT-1:0]    dec_blk,
  input logic [NT-1:0]    dec_unblk,
  input logic [NT-1:0]    ren_blk,
  input logic [NT-1:0]    ren_unblk,
  input logic [NT-1:0]    exe_blk,
  input logic [NT-1:0]    exe_unblk,
  input logic [NT-1:0]    cmt_blk,
  input logic [NT-1:0]    cmt_unblk,
  input logic [NT-1:0]    fl_dec,
  input logic [NT-1:0]    fl_ren,
  input logic [NT-1:0]    fl_exe,
  input logic [NT-1:0]    fl_cmt,
  input logic [NT*3-1:0]  status_o,
  input logic [NT*AW-1:0] pc_o,
  input logic [NT*AW-1:0] cmt_pc,
  input logic [NT-1:0]    miss_drop
);
  for (genvar g = 0; g < NT; g++) begin : g_thr
    // R3
    cmt_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_sq[g] |=> (status_o[g*3 +: 3] == 3'd1) && (pc_o[g*AW +: AW] == $past(cmt_pc[g*AW +: AW])));
    // R4
    rob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmt_sq[g] && rob_busy[g]) |=> (status_o[g*3 +: 3] == 3'd1) && $stable(pc_o[g*AW +: AW]));
    // R6
    wait_exempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[g*3 +: 3] == 3'd3 && !cmt_sq[g] && !rob_busy[g] && !dec_sq[g] && !ic_resp[g])
      |=> status_o[g*3 +: 3] == 3'd3);
    // R8
    retry_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[g*3 +: 3] == 3'd4 && ic_retry_ok[g] && !cmt_sq[g] && !rob_busy[g] && !dec_sq[g])
      |=> status_o[g*3 +: 3] == 3'd3);
    // R9
    drop_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_drop[g] |-> ($past(status_o[g*3 +: 3]) == 3'd3 || $past(status_o[g*3 +: 3]) == 3'd4));
    // R2
    unblock_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_unblk[g] || (fl_dec[g] && !dec_blk[g])) && (!ren_unblk[g] || (fl_ren[g] && !ren_blk[g])) &&
      (!exe_unblk[g] || (fl_exe[g] && !exe_blk[g])) && (!cmt_unblk[g] || (fl_cmt[g] && !cmt_blk[g])));
  end
endmodule

bind fetch_thread_status fetch_thread_status_chk #(.NT(NTHR), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmt_sq(cmt_sq), .rob_busy(rob_busy), .dec_sq(dec_sq),
  .ic_resp(ic_resp), .ic_retry_ok(ic_retry_ok),
  .dec_blk(dec_blk), .dec_unblk(dec_unblk), .ren_blk(ren_blk), .ren_unblk(ren_unblk),
  .exe_blk(exe_blk), .exe_unblk(exe_unblk), .cmt_blk(cmt_blk), .cmt_unblk(cmt_unblk),
  .fl_dec(fl_dec), .fl_ren(fl_ren), .fl_exe(fl_exe), .fl_cmt(fl_cmt),
  .status_o(status_o), .pc_o(pc_o), .cmt_pc(cmt_pc), .miss_drop(miss_drop)
);

// File: tb/test_fetch_thread_status.sv
module test_fetch_thread_status;
  localparam int N = 2;
  localparam int AW = 32;
  localparam int ISZ = 4;
  localparam logic [31:0] RPC = 32'h0000_1000;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] thr_act, dec_blk, dec_unblk, ren_blk, ren_unblk, exe_blk, exe_unblk;
  logic [N-1:0] cmt_blk, cmt_unblk, cmt_sq, rob_busy, dec_sq;
  logic [N-1:0] ic_req, ic_nack, ic_resp, ic_retry_ok;
  logic ctx_sw;
  logic [N*AW-1:0] cmt_pc, cmt_npc, dec_pc, dec_npc;
  logic [N*3-1:0] status_o;
  logic [N*AW-1:0] pc_o, npc_o, nnpc_o;
  logic [N-1:0] miss_drop, status_chg;
  logic stage_active;

  always #4 clk = ~clk;

  fetch_thread_status #(.NTHR(N), .AW(AW), .ISZ(ISZ), .RST_PC(RPC)) i_fetch_thread_status (
    .clk(clk), .rst_n(rst_n), .thr_act(thr_act),
    .dec_blk(dec_blk), .dec_unblk(dec_unblk), .ren_blk(ren_blk), .ren_unblk(ren_unblk),
    .exe_blk(exe_blk), .exe_unblk(exe_unblk), .cmt_blk(cmt_blk), .cmt_unblk(cmt_unblk),
    .ctx_sw(ctx_sw), .cmt_sq(cmt_sq), .cmt_pc(cmt_pc), .cmt_npc(cmt_npc),
    .rob_busy(rob_busy), .dec_sq(dec_sq), .dec_pc(dec_pc), .dec_npc(dec_npc),
    .ic_req(ic_req), .ic_nack(ic_nack), .ic_resp(ic_resp), .ic_retry_ok(ic_retry_ok),
    .status_o(status_o), .pc_o(pc_o), .npc_o(npc_o), .nnpc_o(nnpc_o),
    .miss_drop(miss_drop), .status_chg(status_chg), .stage_active(stage_active));

  int n_tests = 0;
  int n_fail = 0;
  string cur_req = "R1";

  int m_st [N];
  bit m_fd [N], m_fr [N], m_fe [N], m_fc [N];
  logic [31:0] m_pc [N], m_npc [N], m_nnpc [N];
  bit m_drop [N], m_chg [N];

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit act_exp;
    act_exp = 0;
    for (int t = 0; t < N; t++) begin
      chk($sformatf("status[%0d]", t), 32'(status_o[t*3 +: 3]), 32'(m_st[t]));
      chk($sformatf("pc[%0d]", t), pc_o[t*AW +: AW], m_pc[t]);
      chk($sformatf("npc[%0d]", t), npc_o[t*AW +: AW], m_npc[t]);
      chk($sformatf("nnpc[%0d]", t), nnpc_o[t*AW +: AW], m_nnpc[t]);
      chk($sformatf("miss_drop[%0d] R9", t), 32'(miss_drop[t]), 32'(m_drop[t]));
      chk($sformatf("status_chg[%0d] R11", t), 32'(status_chg[t]), 32'(m_chg[t]));
      if (thr_act[t] && (m_st[t] == 0 || m_st[t] == 1 || m_st[t] == 5)) act_exp = 1;
    end
    chk("stage_active R10", 32'(stage_active), 32'(act_exp));
  endtask

  task automatic clr();
    {dec_blk, dec_unblk, ren_blk, ren_unblk, exe_blk, exe_unblk, cmt_blk, cmt_unblk} = '0;
    {cmt_sq, rob_busy, dec_sq, ic_req, ic_nack, ic_resp, ic_retry_ok} = '0;
    ctx_sw = 0;
  endtask

  task automatic step();
    for (int t = 0; t < N; t++) begin
      bit fd, fr, fe, fc, stl, wt;
      fd = dec_blk[t] || (m_fd[t] && !dec_unblk[t]);
      fr = ren_blk[t] || (m_fr[t] && !ren_unblk[t]);
      fe = exe_blk[t] || (m_fe[t] && !exe_unblk[t]);
      fc = cmt_blk[t] || (m_fc[t] && !cmt_unblk[t]);
      stl = fd || fr || fe || fc || ctx_sw;
      wt = (m_st[t] == 3) || (m_st[t] == 4);
      m_drop[t] = 0;
      m_chg[t] = 1;
      if (cmt_sq[t]) begin
        m_drop[t] = wt; m_st[t] = 1;
        m_pc[t] = cmt_pc[t*AW +: AW]; m_npc[t] = cmt_npc[t*AW +: AW]; m_nnpc[t] = m_npc[t] + ISZ;
      end else if (rob_busy[t]) begin
        m_drop[t] = wt; m_st[t] = 1;
      end else if (dec_sq[t] && m_st[t] != 1) begin
        m_drop[t] = wt; m_st[t] = 1;
        m_pc[t] = dec_pc[t*AW +: AW]; m_npc[t] = dec_npc[t*AW +: AW]; m_nnpc[t] = m_npc[t] + ISZ;
      end else if (stl && !wt) m_st[t] = 2;
      else if (m_st[t] == 2 || m_st[t] == 1) m_st[t] = 0;
      else if ((m_st[t] == 0 || m_st[t] == 5) && ic_req[t]) m_st[t] = ic_nack[t] ? 4 : 3;
      else if (m_st[t] == 3 && ic_resp[t]) m_st[t] = stl ? 2 : 5;
      else if (m_st[t] == 4 && ic_retry_ok[t]) m_st[t] = 3;
      else m_chg[t] = 0;
      m_fd[t] = fd; m_fr[t] = fr; m_fe[t] = fe; m_fc[t] = fc;
    end
    @(posedge clk);
    #2;
    compare();
  endtask

  task automatic set_redir(int t, logic [31:0] cp, logic [31:0] dp);
    cmt_pc[t*AW +: AW] = cp; cmt_npc[t*AW +: AW] = cp + 32'h40;
    dec_pc[t*AW +: AW] = dp; dec_npc[t*AW +: AW] = dp + 32'h80;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clr();
    thr_act = 2'b11;
    cmt_pc = '0; cmt_npc = '0; dec_pc = '0; dec_npc = '0;
    for (int t = 0; t < N; t++) begin
      m_st[t] = 0; m_fd[t] = 0; m_fr[t] = 0; m_fe[t] = 0; m_fc[t] = 0;
      m_pc[t] = RPC; m_npc[t] = RPC + ISZ; m_nnpc[t] = RPC + 2 * ISZ;
      m_drop[t] = 0; m_chg[t] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    cur_req = "R1";
    compare();

    cur_req = "R2";
    dec_blk = 2'b01; step();
    clr(); step();
    ren_blk = 2'b10; exe_blk = 2'b01; step();
    clr(); dec_unblk = 2'b01; step();
    cur_req = "R7";
    clr(); exe_unblk = 2'b01; ren_unblk = 2'b10; step();
    cur_req = "R2";
    clr(); cmt_blk = 2'b11; step();
    cur_req = "R7";
    clr(); cmt_unblk = 2'b11; step();

    cur_req = "R6";
    clr(); ic_req = 2'b01; step();
    clr(); ctx_sw = 1; step();
    cur_req = "R8";
    clr(); ctx_sw = 1; ic_resp = 2'b01; step();
    cur_req = "R7";
    clr(); step();

    cur_req = "R8";
    clr(); ic_req = 2'b11; ic_nack = 2'b10; step();
    clr(); step();
    clr(); ic_retry_ok = 2'b10; step();
    clr(); ic_resp = 2'b11; step();
    clr(); ic_resp = 2'b01; step();
    clr(); ic_req = 2'b01; step();

    cur_req = "R9";
    set_redir(0, 32'h0000_2000, 32'h0000_3000);
    clr(); cmt_sq = 2'b01; step();
    clr(); step();

    cur_req = "R3";
    set_redir(0, 32'h0000_4400, 32'h0000_5500);
    set_redir(1, 32'h0000_6600, 32'h0000_7700);
    clr(); cmt_sq = 2'b11; rob_busy = 2'b11; dec_sq = 2'b11; dec_blk = 2'b11; step();
    clr(); dec_unblk = 2'b11; step();

    cur_req = "R4";
    set_redir(0, 32'h0000_8800, 32'h0000_9900);
    clr(); rob_busy = 2'b01; step();
    clr(); rob_busy = 2'b01; dec_sq = 2'b01; step();
    clr(); rob_busy = 2'b01; step();

    cur_req = "R5";
    clr(); dec_sq = 2'b01; step();
    clr(); dec_sq = 2'b01; step();
    clr(); step();

    cur_req = "R10";
    thr_act = 2'b01;
    clr(); ctx_sw = 1; step();
    clr(); ctx_sw = 1; step();
    thr_act = 2'b10;
    clr(); step();
    thr_act = 2'b00;
    clr(); step();
    thr_act = 2'b11;

    cur_req = "R11";
    clr(); step();
    clr(); step();

    cur_req = "R8";
    for (int i = 0; i < 4000; i++) begin
      clr();
      for (int t = 0; t < N; t++) begin
        int r;
        r = $urandom % 10; if (r == 0) dec_blk[t] = 1; else if (r == 1 && m_fd[t]) dec_unblk[t] = 1;
        r = $urandom % 10; if (r == 0) ren_blk[t] = 1; else if (r == 1 && m_fr[t]) ren_unblk[t] = 1;
        r = $urandom % 10; if (r == 0) exe_blk[t] = 1; else if (r == 1 && m_fe[t]) exe_unblk[t] = 1;
        r = $urandom % 10; if (r == 0) cmt_blk[t] = 1; else if (r == 1 && m_fc[t]) cmt_unblk[t] = 1;
        cmt_sq[t] = ($urandom % 16) == 0;
        rob_busy[t] = ($urandom % 12) == 0;
        dec_sq[t] = ($urandom % 10) == 0;
        ic_req[t] = ($urandom % 3) == 0;
        ic_nack[t] = ic_req[t] && (($urandom % 3) == 0);
        ic_resp[t] = ($urandom % 3) == 0;
        ic_retry_ok[t] = ($urandom % 3) == 0;
        set_redir(t, $urandom, $urandom);
      end
      ctx_sw = ($urandom % 20) == 0;
      thr_act = 2'($urandom);
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule